// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches 28 asynchronous interrupt pins. Each pin is first brought into the clock domain. A per-line trigger detector then raises a pending flag when it sees a low level, a high level, a falling edge, a rising edge or either edge, whichever the line is configured for. Each pending flag is gated by a per-line mask bit. The unmasked flags are combined into four interrupt request outputs of uneven width, which an upstream vectored interrupt controller consumes.

Software reaches the block through a single-cycle request port made of valid, write, address and write data. Two configuration words hold the trigger fields, and each field is shared by a pair of adjacent lines. A mask word gates the lines. A pending word is read to find the source and is written with ones to acknowledge. Read data appears on a registered output on the cycle after the request.

Top module: `eint_ctrl`

## Requirements
- R1: Only lines 0 to 27 exist. Mask and pending bits 31:28 ignore writes and read as 0. Configuration word 1 bits 31:24 ignore writes and read as 0.
- R2: Address 0 selects configuration word 0 (lines 0-15), address 1 selects configuration word 1 (lines 16-27), address 2 selects the mask word and address 3 selects the pending word. A read request returns its data on `rd_data` after the next rising clock edge.
- R3: Line n uses the 3-bit field at bit ((n mod 16)/2)*4 of its configuration word, so lines 2k and 2k+1 share one field. Bit 3 of every 4-bit slot reads as 0.
- R4: Field value 000 triggers on a low level and 001 triggers on a high level.
- R5: Field values 010/011 trigger on a falling edge, 100/101 on a rising edge and 110/111 on both edges.
- R6: A mask bit of 1 keeps its line off the group outputs, and a mask bit of 0 lets it through.
- R7: Writing a 1 to a pending bit clears it. Pending bits written with 0 keep their value.
- R8: In a level mode, a pending bit is set again on every cycle the active level is present, so a clear has no lasting effect while that level is held.
- R9: When a trigger event and a clear of the same line fall in the same cycle, the pending bit stays set.
- R10: `irq_grp[0..3]` are registered ORs of (pending AND NOT mask) over lines 0-3, 4-11, 12-19 and 20-27.
- R11: After reset, the configuration words and pending bits are 0, the mask is all ones for lines 0-27, and `irq_grp` is 0.
- R12: Each pin passes through two synchronizing flops. The pending bit is set on the third rising edge after a pin change, and the group output follows on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_in | input | 28 | Asynchronous external interrupt pins |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_grp | output | 4 | Grouped interrupt requests |

## Verification
The hardest case to reach from the ports is a trigger event landing in exactly the same cycle as a write-one-to-clear of the same line. Two flops of synchronizer latency and one flop of edge history stand between the pin and the detector. The bench raises the pin on a falling clock edge and asserts the clear write two cycles later, so the write is captured on the edge where the rising edge is detected. It then reads the pending word back to confirm that the event won. Level re-arm against a clear, and a clear on a pair-shared field where only one line of the pair fired, are driven in the same directed way.

// File: rtl/eint_pkg.sv
package eint_pkg;

  // Trigger evaluation for one line: mode field, synchronized level, level one cycle earlier
  function automatic logic trig_hit(input logic [2:0] mode, input logic cur, input logic prev);
    logic hit;
    case (mode[2:1])
      2'b00:   hit = mode[0] ? cur : ~cur;
      2'b01:   hit = prev & ~cur;
      2'b10:   hit = ~prev & cur;
      default: hit = prev ^ cur;
    endcase
    return hit;
  endfunction

  // First line of group g; group 0 is narrower than the others
  function automatic int grp_lo(input int g, input int first, input int size);
    return (g == 0) ? 0 : first + (g - 1) * size;
  endfunction

  function automatic int grp_hi(input int g, input int first, input int size);
    return (g == 0) ? first - 1 : first + g * size - 1;
  endfunction

  function automatic int grp_of(input int n, input int first, input int size);
    return (n < first) ? 0 : 1 + (n - first) / size;
  endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;

endmodule

// File: rtl/eint_line.sv
module eint_line (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_s,
  input  logic [2:0] mode,
  input  logic       clr,
  output logic       pend
);

  logic prev_q;
  logic pend_q;
  logic hit;

  assign hit = eint_pkg::trig_hit(mode, pin_s, prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      // a fresh event takes priority over an acknowledge in the same cycle
      pend_q <= hit | (pend_q & ~clr);
    end
  end

  assign pend = pend_q;

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !pend_q);

  a_r7_hold_without_clear: assert property (@(posedge clk) disable iff (rst)
    (!clr && pend_q) |=> pend_q);

  a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && hit) |=> pend_q);

  a_r8_high_level_rearms: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b001 && pin_s) |=> pend_q);

  a_r5_rise_edge: assert property (@(posedge clk) disable iff (rst)
    (mode[2:1] == 2'b10 && pin_s && !prev_q) |=> pend_q);

endmodule

// File: rtl/eint_group.sv
module eint_group #(
  parameter int NUM_LINES = 28,
  parameter int NUM_GRPS  = 4,
  parameter int FIRST_GRP = 4,
  parameter int GRP_SIZE  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] active,
  output logic [NUM_GRPS-1:0]  grp_irq
);

  logic [NUM_GRPS-1:0] grp_d;
  logic [NUM_GRPS-1:0] grp_q;

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    localparam int LO = eint_pkg::grp_lo(g, FIRST_GRP, GRP_SIZE);
    localparam int HI = eint_pkg::grp_hi(g, FIRST_GRP, GRP_SIZE);
    assign grp_d[g] = |active[HI:LO];
  end

  always_ff @(posedge clk) begin
    if (rst) grp_q <= '0;
    else     grp_q <= grp_d;
  end

  assign grp_irq = grp_q;

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl #(
  parameter int NUM_LINES = 28,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int NUM_GRPS  = 4,
  parameter int FIRST_GRP = 4,
  parameter int GRP_SIZE  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] ext_irq_in,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_GRPS-1:0]  irq_grp
);

  localparam int FIELD_W     = 3;
  localparam int FIELD_PITCH = 4;
  localparam int FPR         = DATA_W / FIELD_PITCH;
  localparam int NUM_PAIRS   = (NUM_LINES + 1) / 2;
  localparam int NUM_CFG     = (NUM_PAIRS + FPR - 1) / FPR;
  localparam int MASK_ADDR   = NUM_CFG;
  localparam int PEND_ADDR   = NUM_CFG + 1;
  localparam int PAD_W       = DATA_W - NUM_LINES;

  logic                   wr_en;
  logic                   rd_en;
  logic [FIELD_W-1:0]     cfg_q [NUM_PAIRS];
  logic [NUM_LINES-1:0]   mask_q;
  logic [NUM_LINES-1:0]   pend;
  logic [NUM_LINES-1:0]   clr_vec;
  logic [NUM_LINES-1:0]   pin_s;
  logic [DATA_W-1:0]      cfg_word [NUM_CFG];
  logic [DATA_W-1:0]      rd_mux;
  logic [DATA_W-1:0]      rd_q;

  assign wr_en   = req_valid & req_write;
  assign rd_en   = req_valid & ~req_write;
  assign clr_vec = (wr_en && int'(req_addr) == PEND_ADDR) ? req_wdata[NUM_LINES-1:0] : '0;

  // trigger fields, one per line pair
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PAIRS; p++) cfg_q[p] <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (int'(req_addr) == p / FPR)
          cfg_q[p] <= req_wdata[(p % FPR) * FIELD_PITCH +: FIELD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                     mask_q <= '1;
    else if (wr_en && int'(req_addr) == MASK_ADDR) mask_q <= req_wdata[NUM_LINES-1:0];
  end

  eint_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_irq_in),
    .sync_out (pin_s)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    eint_line u_line (
      .clk   (clk),
      .rst   (rst),
      .pin_s (pin_s[n]),
      .mode  (cfg_q[n / 2]),
      .clr   (clr_vec[n]),
      .pend  (pend[n])
    );
  end

  eint_group #(
    .NUM_LINES (NUM_LINES),
    .NUM_GRPS  (NUM_GRPS),
    .FIRST_GRP (FIRST_GRP),
    .GRP_SIZE  (GRP_SIZE)
  ) u_group (
    .clk     (clk),
    .rst     (rst),
    .active  (pend & ~mask_q),
    .grp_irq (irq_grp)
  );

  // read-back words
  always_comb begin
    for (int r = 0; r < NUM_CFG; r++) cfg_word[r] = '0;
    for (int p = 0; p < NUM_PAIRS; p++)
      cfg_word[p / FPR][(p % FPR) * FIELD_PITCH +: FIELD_W] = cfg_q[p];
  end

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < NUM_CFG; r++)
      if (int'(req_addr) == r) rd_mux = cfg_word[r];
    if (int'(req_addr) == MASK_ADDR) rd_mux = {{PAD_W{1'b0}}, mask_q};
    if (int'(req_addr) == PEND_ADDR) rd_mux = {{PAD_W{1'b0}}, pend};
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

  a_r2_mask_readback: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(req_addr) == MASK_ADDR) |=> rd_data == {{PAD_W{1'b0}}, $past(mask_q)});

  a_r6_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> irq_grp == '0);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
    localparam int G = eint_pkg::grp_of(n, FIRST_GRP, GRP_SIZE);
    a_r10_line_reaches_group: assert property (@(posedge clk) disable iff (rst)
      (pend[n] && !mask_q[n]) |=> irq_grp[G]);
  end

endmodule

// File: tb/eint_ctrl_bench.sv
module eint_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CFG0 = 2'd0;
  localparam logic [1:0] A_CFG1 = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_PEND = 2'd3;
  localparam logic [31:0] ALL_LINES = 32'h0FFF_FFFF;

  // {line[4:0], mode[2:0], pin_before, pin_after, expected_pending}
  localparam int NVEC = 12;
  localparam logic [10:0] VEC [NVEC] = '{
    {5'd0,  3'b001, 1'b0, 1'b1, 1'b1},
    {5'd5,  3'b000, 1'b1, 1'b0, 1'b1},
    {5'd13, 3'b010, 1'b1, 1'b0, 1'b1},
    {5'd13, 3'b011, 1'b0, 1'b1, 1'b0},
    {5'd16, 3'b100, 1'b0, 1'b1, 1'b1},
    {5'd21, 3'b101, 1'b1, 1'b0, 1'b0},
    {5'd27, 3'b110, 1'b1, 1'b0, 1'b1},
    {5'd26, 3'b111, 1'b0, 1'b1, 1'b1},
    {5'd9,  3'b001, 1'b1, 1'b0, 1'b1},
    {5'd18, 3'b000, 1'b1, 1'b1, 1'b0},
    {5'd3,  3'b110, 1'b0, 1'b0, 1'b0},
    {5'd20, 3'b100, 1'b1, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [27:0] pins;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic [3:0]  irq_grp;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] rv;
  logic [10:0] ent;
  int lnum, grp, sh;
  logic [2:0] md;
  logic bef, aft, exp_b;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eint_ctrl u_eint_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ext_irq_in (pins),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_data    (rd_data),
    .irq_grp    (irq_grp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rd_data;
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; pins = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 irq_grp after reset", {28'd0, irq_grp}, 32'd0);
    rd(A_MASK, rv); check("R11 R6 mask reset", rv, ALL_LINES);
    rd(A_CFG0, rv); check("R11 cfg0 reset", rv, 32'd0);
    rd(A_CFG1, rv); check("R11 cfg1 reset", rv, 32'd0);
    idle(6);
    rd(A_PEND, rv); check("R4 low-level default with idle pins", rv, ALL_LINES);
    check("R6 masked lines keep groups low", {28'd0, irq_grp}, 32'd0);

    // R1 R3 unused bits
    wr(A_CFG0, 32'hFFFF_FFFF); rd(A_CFG0, rv); check("R3 cfg0 slot bit3 reads 0", rv, 32'h7777_7777);
    wr(A_CFG1, 32'hFFFF_FFFF); rd(A_CFG1, rv); check("R1 cfg1 upper fields absent", rv, 32'h0077_7777);
    wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, rv); check("R1 mask bits 31:28 absent", rv, ALL_LINES);
    wr(A_CFG0, 32'd0); wr(A_CFG1, 32'd0);

    // R2 R4 R5 R6 R10 table of trigger cases
    for (int i = 0; i < NVEC; i++) begin
      ent = VEC[i];
      lnum = int'(ent[10:6]); md = ent[5:3]; bef = ent[2]; aft = ent[1]; exp_b = ent[0];
      grp = (lnum < 4) ? 0 : (lnum < 12) ? 1 : (lnum < 20) ? 2 : 3;
      sh = ((lnum % 16) / 2) * 4;
      wr((lnum < 16) ? A_CFG0 : A_CFG1, 32'(md) << sh);
      pins = '0; pins[lnum] = bef;
      wr(A_MASK, ALL_LINES & ~(32'd1 << lnum));
      idle(6);
      wr(A_PEND, 32'd1 << lnum);
      idle(1);
      pins[lnum] = aft;
      idle(6);
      rd(A_PEND, rv);
      check($sformatf("R4 R5 vector %0d pending", i), {31'd0, rv[lnum]}, {31'd0, exp_b});
      check($sformatf("R10 vector %0d group", i), {28'd0, irq_grp}, {28'd0, 4'(exp_b) << grp});
      wr(A_MASK, ALL_LINES);
    end
    pins = '0;
    wr(A_CFG1, 32'd0);

    // R3 pair sharing: lines 4 and 5 follow field 2 (rising)
    wr(A_CFG0, 32'h0000_0400);
    idle(6);
    wr(A_PEND, 32'h30);
    pins[5] = 1'b1;
    idle(6);
    rd(A_PEND, rv); check("R3 only line 5 fired", rv & 32'h30, 32'h20);
    pins[4] = 1'b1;
    idle(6);
    rd(A_PEND, rv); check("R3 line 4 shares rising field", rv & 32'h30, 32'h30);

    // R7 write-one-to-clear
    wr(A_PEND, 32'hF000_0000);
    rd(A_PEND, rv); check("R7 zero bits keep pending", rv & 32'h30, 32'h30);
    wr(A_PEND, 32'h10);
    rd(A_PEND, rv); check("R7 one clears only its line", rv & 32'h30, 32'h20);

    // R8 level re-arm, line 0 high level
    pins = '0;
    wr(A_CFG0, 32'h0000_0001);
    pins[0] = 1'b1;
    idle(6);
    wr(A_PEND, 32'h1);
    rd(A_PEND, rv); check("R8 clear ignored while level held", rv & 32'h1, 32'h1);
    pins[0] = 1'b0;
    idle(6);
    wr(A_PEND, 32'h1);
    rd(A_PEND, rv); check("R8 clear sticks after level drops", rv & 32'h1, 32'h0);

    // R12 synchronizer latency
    wr(A_MASK, ALL_LINES & ~32'h1);
    idle(2);
    check("R12 group idle before pin", {28'd0, irq_grp}, 32'd0);
    pins[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 group still low after 3 edges", {31'd0, irq_grp[0]}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R12 group high after 4 edges", {31'd0, irq_grp[0]}, 32'd1);
    pins[0] = 1'b0;
    idle(6);
    wr(A_PEND, 32'h1);
    wr(A_MASK, ALL_LINES);

    // R9 event and clear in the same cycle, line 0 rising
    wr(A_CFG0, 32'h0000_0004);
    idle(6);
    wr(A_PEND, 32'h1);
    idle(2);
    pins[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_PEND; req_wdata = 32'h1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd(A_PEND, rv); check("R9 event wins over clear", rv & 32'h1, 32'h1);
    wr(A_PEND, 32'h1);
    rd(A_PEND, rv); check("R7 later clear takes effect", rv & 32'h1, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule